// File: doc/BRIEF.md
# Store Pipeline with Write-Buffer Enqueue

This block carries a store through three pipeline stages into a direct-mapped data cache. It also hands every store to an external write buffer. In the address stage it adds base and displacement to form the effective address, and it launches a read of the synchronous tag array at that address's line index. In the lookup stage it compares the returned tag against the address and settles hit or miss. In that same cycle it offers the store to the write buffer, whatever the outcome. In the write stage, one cycle later, the block drives the data-array write port, but only for a store that hit. A miss leaves the cache untouched, so the store lives only in the write buffer.

The cache has 64 lines of 32 bytes. Each store carries 64 bits of data and an 8-bit byte enable. An effective address splits into tag `[31:11]`, line index `[10:5]` and word-in-line `[4:3]`; bits `[2:0]` take no part, because the byte enable selects the bytes. The lookup stage is a three-state machine:
- `ENQ_IDLE` means no store is held.
- `ENQ_LOOKUP` means a store arrived at the last edge.
- `ENQ_HOLD` means a store is waiting on a full write buffer.

Its transitions are:
- *accept*: any state goes to `ENQ_LOOKUP` when a store is taken.
- *drain*: an occupied state goes to `ENQ_IDLE` when its store is enqueued and no new store arrives.
- *block*: an occupied state goes to `ENQ_HOLD` while the buffer is full.

While a store is held, the stall request goes back to issue, and the tag array is re-read at the held store's index so that its compare stays current. Tags are placed in the array through a separate install port, which the fill side uses. Fill and drain themselves lie outside the block.

Top module: `store_path_pipe`

## Requirements
- R1: After reset, `wb_enq_valid`, `dwr_en` and `stall_req` are 0, and every cache line is invalid, so the first store to any line misses.
- R2: The effective address is `st_base + st_disp` modulo 2^32. A store presented with `st_valid` at a clock edge appears on `wb_enq_addr`/`wb_enq_data`/`wb_enq_mask` in the following cycle with `wb_enq_valid` high, provided `wb_full` is low.
- R3: Every accepted store is enqueued exactly once, hit or miss, and `wb_enq_valid` is never high while `wb_full` is high.
- R4: A store that hits raises `dwr_en` for one cycle, exactly one cycle after its enqueue. `dwr_index` = address `[10:5]`, `dwr_word` = address `[4:3]`, and `dwr_data`/`dwr_mask` are the store's data and byte enable.
- R5: A store that misses never raises `dwr_en`, and it does not allocate a line, so a repeat store to the same address misses again.
- R6: When a store sits in the lookup stage and `wb_full` is high, `stall_req` is high and nothing is enqueued. The store is held unchanged, and it is enqueued with its original values, with its hit decision intact, in the first cycle `wb_full` is low.
- R7: While `stall_req` is high, `st_valid` is ignored, and no store presented then is ever enqueued.
- R8: Stores presented on consecutive cycles are enqueued on consecutive cycles. Each one's data write, for the hits among them, follows one cycle after its own enqueue.
- R9: A hit requires a valid line whose stored tag equals address `[31:11]`. A store with the same index and a different tag misses. A later install at an index replaces the tag that was there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store presented this cycle |
| st_base | input | 32 | Base register value |
| st_disp | input | 32 | Displacement |
| st_data | input | 64 | Store data |
| st_mask | input | 8 | Byte enables |
| stall_req | output | 1 | Store held in lookup stage; issue must hold |
| wb_full | input | 1 | Write buffer cannot accept this cycle |
| wb_enq_valid | output | 1 | Enqueue strobe to write buffer |
| wb_enq_addr | output | 32 | Enqueued effective address |
| wb_enq_data | output | 64 | Enqueued data |
| wb_enq_mask | output | 8 | Enqueued byte enables |
| tag_wr_en | input | 1 | Install a tag (marks line valid) |
| tag_wr_index | input | 6 | Line to install |
| tag_wr_tag | input | 21 | Tag to install |
| dwr_en | output | 1 | Data-array write strobe |
| dwr_index | output | 6 | Data-array line |
| dwr_word | output | 2 | 64-bit word within the line |
| dwr_data | output | 64 | Write data |
| dwr_mask | output | 8 | Byte enables for the write |

## Verification
The hardest case to reach from the ports is a hit whose enqueue is held by a full write buffer for several cycles, while issue keeps presenting another store. There the tag array must be re-read at the held index, and the late data write must still carry the held store's fields. The stimulus installs the tag first and raises `wb_full` before the store is presented. It then presents a second store during the stall and releases `wb_full` only after several held cycles. After the release, the data write must follow one cycle behind the enqueue, and the ignored store must never appear.

// File: rtl/store_pipe_pkg.sv
package store_pipe_pkg;
    parameter int ADDR_W     = 32;
    parameter int DATA_W     = 64;
    parameter int LINE_BYTES = 32;
    parameter int NUM_LINES  = 64;

    localparam int MASK_W = DATA_W / 8;
    localparam int OFS_W  = $clog2(LINE_BYTES);
    localparam int BYTE_W = $clog2(MASK_W);
    localparam int WORD_W = OFS_W - BYTE_W;
    localparam int IDX_W  = $clog2(NUM_LINES);
    localparam int TAG_W  = ADDR_W - IDX_W - OFS_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [MASK_W-1:0] mask;
    } store_req_t;

    typedef enum logic [1:0] {
        ENQ_IDLE,
        ENQ_LOOKUP,
        ENQ_HOLD
    } enq_state_t;

    function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
        return a[OFS_W +: IDX_W];
    endfunction

    function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: TAG_W];
    endfunction

    function automatic logic [WORD_W-1:0] word_of(input logic [ADDR_W-1:0] a);
        return a[BYTE_W +: WORD_W];
    endfunction
endpackage

// File: rtl/store_agen.sv
module store_agen
    import store_pipe_pkg::*;
(
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] disp,
    input  logic [DATA_W-1:0] data,
    input  logic [MASK_W-1:0] mask,
    output store_req_t        req,
    output logic [IDX_W-1:0]  index
);
    always_comb begin
        req.addr = base + disp;
        req.data = data;
        req.mask = mask;
        index    = idx_of(req.addr);
    end
endmodule

// File: rtl/store_tag_array.sv
module store_tag_array
    import store_pipe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_index,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_valid,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_index,
    input  logic [TAG_W-1:0] wr_tag
);
    logic [TAG_W-1:0]     tag_mem [NUM_LINES];
    logic [NUM_LINES-1:0] line_vld;

    // Tag storage: no reset, validity tracked separately.
    always_ff @(posedge clk) begin
        if (wr_en) tag_mem[wr_index] <= wr_tag;
        rd_tag <= tag_mem[rd_index];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_vld <= '0;
            rd_valid <= 1'b0;
        end else begin
            if (wr_en) line_vld[wr_index] <= 1'b1;
            rd_valid <= line_vld[rd_index];
        end
    end
endmodule

// File: rtl/store_enq_stage.sv
module store_enq_stage
    import store_pipe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  store_req_t       in_req,
    input  logic             wb_full,
    input  logic [TAG_W-1:0] tag_q,
    input  logic             tag_vld_q,
    output logic             stall,
    output logic             enq_valid,
    output logic             hit,
    output store_req_t       held_req
);
    enq_state_t state, state_nx;
    logic       occupied;
    logic       accept;

    always_comb begin
        occupied = (state != ENQ_IDLE);
        stall    = occupied && wb_full;
        accept   = in_valid && !stall;
        state_nx = state;
        unique case (state)
            ENQ_IDLE:   state_nx = accept ? ENQ_LOOKUP : ENQ_IDLE;
            ENQ_LOOKUP,
            ENQ_HOLD:   state_nx = wb_full ? ENQ_HOLD
                                 : (accept ? ENQ_LOOKUP : ENQ_IDLE);
            default:    state_nx = ENQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ENQ_IDLE;
            held_req <= '0;
        end else begin
            state <= state_nx;
            if (accept) held_req <= in_req;
        end
    end

    always_comb begin
        enq_valid = occupied && !wb_full;
        hit       = occupied && tag_vld_q && (tag_q == tag_of(held_req.addr));
    end
endmodule

// File: rtl/store_path_pipe.sv
module store_path_pipe
    import store_pipe_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 st_valid,
    input  logic [ADDR_W-1:0]    st_base,
    input  logic [ADDR_W-1:0]    st_disp,
    input  logic [DATA_W-1:0]    st_data,
    input  logic [MASK_W-1:0]    st_mask,
    output logic                 stall_req,
    input  logic                 wb_full,
    output logic                 wb_enq_valid,
    output logic [ADDR_W-1:0]    wb_enq_addr,
    output logic [DATA_W-1:0]    wb_enq_data,
    output logic [MASK_W-1:0]    wb_enq_mask,
    input  logic                 tag_wr_en,
    input  logic [IDX_W-1:0]     tag_wr_index,
    input  logic [TAG_W-1:0]     tag_wr_tag,
    output logic                 dwr_en,
    output logic [IDX_W-1:0]     dwr_index,
    output logic [WORD_W-1:0]    dwr_word,
    output logic [DATA_W-1:0]    dwr_data,
    output logic [MASK_W-1:0]    dwr_mask
);
    store_req_t       ag_req, held_req;
    logic [IDX_W-1:0] ag_index, rd_index;
    logic [TAG_W-1:0] tag_q;
    logic             tag_vld_q, enq_fire, lookup_hit;

    store_agen u_agen (
        .base(st_base), .disp(st_disp), .data(st_data), .mask(st_mask),
        .req(ag_req), .index(ag_index)
    );

    // A held store re-reads its own line so the compare stays current.
    assign rd_index = stall_req ? idx_of(held_req.addr) : ag_index;

    store_tag_array u_tags (
        .clk(clk), .rst_n(rst_n),
        .rd_index(rd_index), .rd_tag(tag_q), .rd_valid(tag_vld_q),
        .wr_en(tag_wr_en), .wr_index(tag_wr_index), .wr_tag(tag_wr_tag)
    );

    store_enq_stage u_enq (
        .clk(clk), .rst_n(rst_n),
        .in_valid(st_valid), .in_req(ag_req), .wb_full(wb_full),
        .tag_q(tag_q), .tag_vld_q(tag_vld_q),
        .stall(stall_req), .enq_valid(enq_fire), .hit(lookup_hit),
        .held_req(held_req)
    );

    assign wb_enq_valid = enq_fire;
    assign wb_enq_addr  = held_req.addr;
    assign wb_enq_data  = held_req.data;
    assign wb_enq_mask  = held_req.mask;

    // Write stage: data-array write one cycle after a hitting enqueue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dwr_en    <= 1'b0;
            dwr_index <= '0;
            dwr_word  <= '0;
            dwr_data  <= '0;
            dwr_mask  <= '0;
        end else begin
            dwr_en    <= enq_fire && lookup_hit;
            dwr_index <= idx_of(held_req.addr);
            dwr_word  <= word_of(held_req.addr);
            dwr_data  <= held_req.data;
            dwr_mask  <= held_req.mask;
        end
    end
endmodule

// File: rtl/store_path_checker.sv
module store_path_checker
    import store_pipe_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              stall_req,
    input logic              wb_full,
    input logic              wb_enq_valid,
    input logic [ADDR_W-1:0] wb_enq_addr,
    input logic [DATA_W-1:0] wb_enq_data,
    input logic [MASK_W-1:0] wb_enq_mask,
    input logic              dwr_en,
    input logic [IDX_W-1:0]  dwr_index,
    input logic [DATA_W-1:0] dwr_data
);
    // R6
    stall_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_req |-> wb_full);

    // R3
    no_enq_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_enq_valid |-> !wb_full);

    // R6
    stall_blocks_enq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_req |-> !wb_enq_valid);

    // R6
    held_store_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_req |=> ($stable(wb_enq_addr) && $stable(wb_enq_data) && $stable(wb_enq_mask)));

    // R4
    write_follows_enq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dwr_en |-> $past(wb_enq_valid));

    // R4
    write_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dwr_en |-> (dwr_index == idx_of($past(wb_enq_addr)) && dwr_data == $past(wb_enq_data)));
endmodule

bind store_path_pipe store_path_checker u_chk (
    .clk(clk), .rst_n(rst_n), .stall_req(stall_req), .wb_full(wb_full),
    .wb_enq_valid(wb_enq_valid), .wb_enq_addr(wb_enq_addr),
    .wb_enq_data(wb_enq_data), .wb_enq_mask(wb_enq_mask),
    .dwr_en(dwr_en), .dwr_index(dwr_index), .dwr_data(dwr_data)
);

// File: tb/store_path_pipe_bench.sv
module store_path_pipe_bench;
    import store_pipe_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              st_valid = 1'b0;
    logic [ADDR_W-1:0] st_base = '0, st_disp = '0;
    logic [DATA_W-1:0] st_data = '0;
    logic [MASK_W-1:0] st_mask = '0;
    logic              stall_req, wb_full = 1'b0;
    logic              wb_enq_valid;
    logic [ADDR_W-1:0] wb_enq_addr;
    logic [DATA_W-1:0] wb_enq_data;
    logic [MASK_W-1:0] wb_enq_mask;
    logic              tag_wr_en = 1'b0;
    logic [IDX_W-1:0]  tag_wr_index = '0;
    logic [TAG_W-1:0]  tag_wr_tag = '0;
    logic              dwr_en;
    logic [IDX_W-1:0]  dwr_index;
    logic [WORD_W-1:0] dwr_word;
    logic [DATA_W-1:0] dwr_data;
    logic [MASK_W-1:0] dwr_mask;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    store_path_pipe u_store_path_pipe (.*);

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] mk(input logic [TAG_W-1:0] t,
                                             input logic [IDX_W-1:0] i,
                                             input logic [WORD_W-1:0] w);
        return {t, i, w, {BYTE_W{1'b0}}};
    endfunction

    task automatic install(input logic [IDX_W-1:0] i, input logic [TAG_W-1:0] t);
        tag_wr_en = 1'b1; tag_wr_index = i; tag_wr_tag = t;
        @(negedge clk);
        tag_wr_en = 1'b0;
    endtask

    task automatic present(input logic [ADDR_W-1:0] b, input logic [ADDR_W-1:0] d,
                           input logic [DATA_W-1:0] x, input logic [MASK_W-1:0] m);
        st_valid = 1'b1; st_base = b; st_disp = d; st_data = x; st_mask = m;
    endtask

    task automatic expect_enq(input string req, input logic [ADDR_W-1:0] a,
                              input logic [DATA_W-1:0] x, input logic [MASK_W-1:0] m);
        chk(req, "enq_valid", wb_enq_valid, 1);
        chk(req, "enq_addr", wb_enq_addr, a);
        chk(req, "enq_data", wb_enq_data, x);
        chk(req, "enq_mask", wb_enq_mask, m);
    endtask

    task automatic expect_write(input string req, input logic [ADDR_W-1:0] a,
                                input logic [DATA_W-1:0] x, input logic [MASK_W-1:0] m);
        chk(req, "dwr_en", dwr_en, 1);
        chk(req, "dwr_index", dwr_index, a[10:5]);
        chk(req, "dwr_word", dwr_word, a[4:3]);
        chk(req, "dwr_data", dwr_data, x);
        chk(req, "dwr_mask", dwr_mask, m);
    endtask

    // One isolated store; enqueue checked next cycle, write the cycle after.
    task automatic run_store(input string req, input logic [ADDR_W-1:0] b,
                             input logic [ADDR_W-1:0] d, input logic [DATA_W-1:0] x,
                             input logic [MASK_W-1:0] m, input bit exp_hit);
        logic [ADDR_W-1:0] ea;
        ea = b + d;
        present(b, d, x, m);
        @(negedge clk);
        st_valid = 1'b0;
        expect_enq(req, ea, x, m);
        chk(req, "dwr_en early", dwr_en, 0);
        @(negedge clk);
        chk(req, "enq once", wb_enq_valid, 0);
        if (exp_hit) expect_write(req, ea, x, m);
        else chk(req, "dwr_en on miss", dwr_en, 0);
    endtask

    task automatic t_reset();
        chk("R1", "enq_valid", wb_enq_valid, 0);
        chk("R1", "dwr_en", dwr_en, 0);
        chk("R1", "stall_req", stall_req, 0);
        run_store("R1", mk(21'h0ABCD, 6'd9, 2'd0), 32'd0, 64'h1111_2222_3333_4444, 8'hFF, 1'b0);
    endtask

    task automatic t_hit();
        logic [ADDR_W-1:0] a;
        a = mk(21'h1234A, 6'd5, 2'd2);
        install(6'd5, 21'h1234A);
        run_store("R4", a - 32'h48, 32'h48, 64'hDEAD_BEEF_0BAD_F00D, 8'h3C, 1'b1);
    endtask

    task automatic t_wrap();
        install(6'd0, 21'd0);
        // R2: 0xFFFF_FFF8 + 0x10 wraps to 0x8 -> index 0, word 1
        run_store("R2", 32'hFFFF_FFF8, 32'h10, 64'h0123_4567_89AB_CDEF, 8'h0F, 1'b1);
    endtask

    task automatic t_miss();
        logic [ADDR_W-1:0] a;
        a = mk(21'h0F0F0, 6'd33, 2'd0);
        run_store("R5", a, 32'd0, 64'h5555, 8'h01, 1'b0);
        run_store("R5", a, 32'd0, 64'h6666, 8'h02, 1'b0);
    endtask

    task automatic t_tag_match();
        install(6'd40, 21'h00111);
        run_store("R9", mk(21'h00222, 6'd40, 2'd1), 32'd0, 64'hA1, 8'h80, 1'b0);
        install(6'd40, 21'h00222);
        run_store("R9", mk(21'h00222, 6'd40, 2'd1), 32'd0, 64'hA2, 8'h40, 1'b1);
        run_store("R9", mk(21'h00111, 6'd40, 2'd3), 32'd0, 64'hA3, 8'h20, 1'b0);
    endtask

    task automatic t_stall();
        logic [ADDR_W-1:0] a;
        a = mk(21'h1F00D, 6'd12, 2'd3);
        install(6'd12, 21'h1F00D);
        wb_full = 1'b1;
        present(a, 32'd0, 64'hCAFE_0000_1234_5678, 8'hF0);
        @(negedge clk);
        chk("R6", "stall_req", stall_req, 1);
        chk("R6", "enq while full", wb_enq_valid, 0);
        // R7: a second store offered during the stall must be ignored
        present(mk(21'h00777, 6'd13, 2'd0), 32'd0, 64'hBAD, 8'hFF);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R6", "stall held", stall_req, 1);
            chk("R6", "enq held", wb_enq_valid, 0);
            chk("R6", "no write during stall", dwr_en, 0);
        end
        wb_full = 1'b0;
        st_valid = 1'b0;
        #1;
        chk("R6", "stall released", stall_req, 0);
        expect_enq("R6", a, 64'hCAFE_0000_1234_5678, 8'hF0);
        @(negedge clk);
        expect_write("R6", a, 64'hCAFE_0000_1234_5678, 8'hF0);
        chk("R7", "ignored store enqueued", wb_enq_valid, 0);
        @(negedge clk);
        chk("R7", "late enq", wb_enq_valid, 0);
        chk("R6", "single write", dwr_en, 0);
    endtask

    task automatic t_back_to_back();
        logic [ADDR_W-1:0] a, b, c;
        a = mk(21'h00AAA, 6'd20, 2'd1);
        b = mk(21'h00AAB, 6'd20, 2'd0);
        c = mk(21'h00AAA, 6'd21, 2'd3);
        install(6'd20, 21'h00AAA);
        install(6'd21, 21'h00AAA);
        present(a, 32'd0, 64'hA, 8'h01);
        @(negedge clk);
        expect_enq("R8", a, 64'hA, 8'h01);
        present(b, 32'd0, 64'hB, 8'h02);
        @(negedge clk);
        expect_enq("R8", b, 64'hB, 8'h02);
        expect_write("R8", a, 64'hA, 8'h01);
        present(c, 32'd0, 64'hC, 8'h04);
        @(negedge clk);
        st_valid = 1'b0;
        expect_enq("R8", c, 64'hC, 8'h04);
        chk("R8", "miss in stream", dwr_en, 0);
        @(negedge clk);
        expect_write("R8", c, 64'hC, 8'h04);
        chk("R8", "stream drained", wb_enq_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hit();
        t_wrap();
        t_miss();
        t_tag_match();
        t_stall();
        t_back_to_back();
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule